// File: doc/BRIEF.md
# Selectable PWM Carrier Generator with Synchronization

This block produces the switching carrier for a two-channel class-D modulator. It emits a ramp count that runs from zero up to one less than the period length, and a one-cycle strobe at the start of each carrier period. A 3-bit rate code picks one of five carrier frequencies, derived from a 48 MHz reference clock by integer division. The code is sampled only at period boundaries, so a period never changes length partway through.

A 3-bit configuration strap is captured once, the first time the start-up-complete input is seen high after reset. After that it holds until the next reset, which stands for the next power-up. The strap selects master or slave operation and a 2-bit gain index, and both are exposed as registered outputs. A master drives a 50% square wave on its sync output, so that several devices can share one carrier clock. A slave leaves the sync line undriven and restarts its ramp on each synchronized rising edge of the incoming sync clock. If that clock goes missing, the slave flags the loss.

Top module: `pwm_carrier_gen`

## Requirements
- R1: While reset is held, and in the first cycle after it, ramp_cnt is 0 and period_start, locked, sync_drive, sync_out, cfg_err and sync_lost are all 0.
- R2: The strap is captured in the first cycle that startup_done is high. Bit 2 selects slave mode (0 = master, 1 = slave) and bits 1:0 give gain_idx (0 = 20 dB, 1 = 26 dB, 2 = 32 dB, 3 = 36 dB). Later changes to the strap or to startup_done have no effect until reset.
- R3: In master mode the distance between period_start strobes is 120, 96, 80, 48 or 40 reference cycles for rate codes 000, 001, 010, 011 and 100. Within a period, ramp_cnt counts up from 0 and stays below the period length.
- R4: A reserved rate code (101, 110, 111) gives a 120-cycle period and sets cfg_err. Once set, cfg_err stays set until reset.
- R5: freq_sel is sampled only at a period boundary. A change made during a period takes effect from the next period.
- R6: In master mode sync_drive is 1, and sync_out is high for the first half of each period (ramp_cnt below half the period length) and low for the rest.
- R7: In slave mode sync_drive and sync_out are 0. A rising edge on sync_in restarts the ramp, so that ramp_cnt is 0 and period_start is 1 in the cycle after the third clock edge that samples sync_in high.
- R8: In slave mode sync_lost rises once 2×N cycles pass without a restart, where N is the nominal period for the selected code. The next restart clears it.
- R9: Before the strap is captured, ramp_cnt stays at 0, no period_start strobe occurs and sync_drive is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 48 MHz reference clock |
| rst_n | input | 1 | Synchronous active-low reset (power-up) |
| startup_done | input | 1 | High once start-up is complete; its first high cycle captures the strap |
| strap_code | input | 3 | Decoded strap state: bit 2 = slave, bits 1:0 = gain index |
| freq_sel | input | 3 | Carrier rate code |
| sync_in | input | 1 | External carrier clock (used in slave mode), asynchronous |
| sync_out | output | 1 | Carrier square wave (used in master mode) |
| sync_drive | output | 1 | Output enable for the shared sync line, high in master mode |
| ramp_cnt | output | 7 | Carrier ramp position within the period |
| period_start | output | 1 | High in the cycle where ramp_cnt is 0 at the start of a period |
| locked | output | 1 | Strap has been captured |
| is_slave | output | 1 | Latched mode bit |
| gain_idx | output | 2 | Latched gain step |
| cfg_err | output | 1 | Sticky flag: a reserved rate code was seen |
| sync_lost | output | 1 | Slave has seen no sync edge for two nominal periods |

## Verification
The assertions assume the strap and the rate code are stable levels from the point of view of the clock. They also assume reset is applied before startup_done first rises, and that sync_in carries a clock whose period is shorter than the nominal carrier period whenever a slave is expected to track it. The stimulus changes freq_sel only on the falling clock edge right after a strobe, changes the strap only after capture to show that the change is ignored, and toggles sync_in on falling edges with a 40-cycle period against a 48-cycle nominal rate. The loss test is the one place sync_in is deliberately left idle for longer than two nominal periods.

// File: rtl/pwm_carrier_pkg.sv
// Package: shared constants, the strap layout and the rate-code decode
// for the carrier generator. Assumes a 48 MHz reference clock.
package pwm_carrier_pkg;

    localparam int unsigned CODE_W   = 3;
    localparam int unsigned GAIN_W   = 2;
    localparam int unsigned DIV_400K = 120;
    localparam int unsigned DIV_500K = 96;
    localparam int unsigned DIV_600K = 80;
    localparam int unsigned DIV_1M   = 48;
    localparam int unsigned DIV_1M2  = 40;
    localparam int unsigned MAX_DIV  = DIV_400K;
    localparam int unsigned CNT_W    = $clog2(MAX_DIV);
    localparam int unsigned AGE_W    = $clog2(2 * MAX_DIV + 1);

    typedef struct packed {
        logic              slave;
        logic [GAIN_W-1:0] gain;
    } strap_t;

    // Map a rate code to its period length in reference cycles.
    function automatic logic [CNT_W-1:0] code_to_div(input logic [CODE_W-1:0] code);
        case (code)
            3'd0:    return CNT_W'(DIV_400K);
            3'd1:    return CNT_W'(DIV_500K);
            3'd2:    return CNT_W'(DIV_600K);
            3'd3:    return CNT_W'(DIV_1M);
            3'd4:    return CNT_W'(DIV_1M2);
            default: return CNT_W'(DIV_400K);
        endcase
    endfunction

    // True for codes that have no rate assigned.
    function automatic logic code_reserved(input logic [CODE_W-1:0] code);
        return code > 3'd4;
    endfunction

endpackage

// File: rtl/pwm_strap_latch.sv
// Captures the mode/gain strap once, on the first high cycle of startup_done,
// and holds it until reset. Assumes the strap is a settled level at that time.
module pwm_strap_latch
    import pwm_carrier_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              startup_done,
    input  logic [CODE_W-1:0] strap_code,
    output logic              locked,
    output strap_t            strap_q
);

    // One-time capture of the strap; later inputs are ignored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked  <= 1'b0;
            strap_q <= '0;
        end else if (!locked && startup_done) begin
            locked  <= 1'b1;
            strap_q <= strap_t'(strap_code);
        end
    end

    p_mode_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> (locked && $stable(strap_q)))
        else $error("R2: latched strap changed after capture");

endmodule

// File: rtl/pwm_sync_edge.sv
// Brings the asynchronous sync clock into the reference domain through a
// STAGES-deep flop chain and flags its rising edge for one cycle.
module pwm_sync_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    output logic rise
);

    logic [STAGES:0] chain;

    // Shift chain: STAGES synchronizer flops plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-1:0], sync_in};
    end

    assign rise = chain[STAGES-1] & ~chain[STAGES];

    p_rise_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise)
        else $error("R7: edge pulse wider than one cycle");

endmodule

// File: rtl/pwm_carrier_counter.sv
// Ramp counter with per-period rate loading, slave restart and sync-loss
// timer. Assumes run stays high once set until reset.
module pwm_carrier_counter
    import pwm_carrier_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              slave,
    input  logic [CODE_W-1:0] freq_sel,
    input  logic              rise,
    output logic [CNT_W-1:0]  cnt,
    output logic [CNT_W-1:0]  div,
    output logic              active,
    output logic              period_start,
    output logic              cfg_err,
    output logic              sync_lost
);

    logic [AGE_W-1:0] age;
    logic [AGE_W-1:0] lost_lim;
    logic             wrap;
    logic             restart;
    logic             load;
    logic [AGE_W-1:0] age_inc;

    assign lost_lim = AGE_W'(div) << 1;
    assign wrap     = (cnt == div - CNT_W'(1));
    assign restart  = slave && rise;
    assign load     = !active || restart || wrap;
    assign age_inc  = (age >= lost_lim) ? age : age + AGE_W'(1);

    // Ramp, period length, error flag and edge-age registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            div     <= CNT_W'(DIV_400K);
            active  <= 1'b0;
            cfg_err <= 1'b0;
            age     <= '0;
        end else if (run) begin
            active <= 1'b1;
            if (load) begin
                cnt     <= '0;
                div     <= code_to_div(freq_sel);
                cfg_err <= cfg_err | code_reserved(freq_sel);
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
            age <= (!active || restart) ? '0 : age_inc;
        end
    end

    assign period_start = active && (cnt == '0);
    assign sync_lost    = active && slave && (age >= lost_lim);

    p_cnt_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < div)
        else $error("R3: ramp count reached period length");

    p_cfg_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err)
        else $error("R4: config error flag cleared");

    p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (active && run && restart) |=> (cnt == '0))
        else $error("R7: ramp not restarted by sync edge");

    p_lost_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (active && run && restart) |=> !sync_lost)
        else $error("R8: sync_lost held after edge");

    p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (cnt == '0 && !period_start))
        else $error("R9: carrier moving before capture");

endmodule

// File: rtl/pwm_carrier_gen.sv
// Top: selectable carrier generator. Latches the strap, runs the ramp as
// master (driving sync_out) or slave (following sync_in).
// Assumes clk is the 48 MHz reference and reset precedes startup_done.
module pwm_carrier_gen
    import pwm_carrier_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              startup_done,
    input  logic [CODE_W-1:0] strap_code,
    input  logic [CODE_W-1:0] freq_sel,
    input  logic              sync_in,
    output logic              sync_out,
    output logic              sync_drive,
    output logic [CNT_W-1:0]  ramp_cnt,
    output logic              period_start,
    output logic              locked,
    output logic              is_slave,
    output logic [GAIN_W-1:0] gain_idx,
    output logic              cfg_err,
    output logic              sync_lost
);

    strap_t           strap_q;
    logic             rise;
    logic             active;
    logic [CNT_W-1:0] div;

    pwm_strap_latch u_strap (
        .clk          (clk),
        .rst_n        (rst_n),
        .startup_done (startup_done),
        .strap_code   (strap_code),
        .locked       (locked),
        .strap_q      (strap_q)
    );

    pwm_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .sync_in (sync_in),
        .rise    (rise)
    );

    pwm_carrier_counter u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .run          (locked),
        .slave        (strap_q.slave),
        .freq_sel     (freq_sel),
        .rise         (rise),
        .cnt          (ramp_cnt),
        .div          (div),
        .active       (active),
        .period_start (period_start),
        .cfg_err      (cfg_err),
        .sync_lost    (sync_lost)
    );

    assign is_slave   = strap_q.slave;
    assign gain_idx   = strap_q.gain;
    assign sync_drive = locked && !strap_q.slave;
    assign sync_out   = sync_drive && active && (ramp_cnt < (div >> 1));

    p_slave_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && is_slave) |-> (!sync_drive && !sync_out))
        else $error("R7: slave driving sync line");

    p_sync_half_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_drive && period_start) |-> sync_out)
        else $error("R6: sync low at period start");

endmodule

// File: tb/pwm_carrier_gen_tb.sv
// Scoreboard bench: driver tasks queue expected period lengths and sync-high
// counts; a monitor measures each period between strobes and compares.
module pwm_carrier_gen_tb_top;
    import pwm_carrier_pkg::*;

    typedef struct {
        int    ivl;
        int    hi;
        string tag;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             startup_done = 1'b0;
    logic [2:0]       strap_code = 3'b000;
    logic [2:0]       freq_sel = 3'b000;
    logic             sync_in = 1'b0;
    logic             sync_out, sync_drive, period_start, locked, is_slave;
    logic             cfg_err, sync_lost;
    logic [CNT_W-1:0] ramp_cnt;
    logic [1:0]       gain_idx;

    int   n_chk = 0;
    int   n_fail = 0;
    exp_t q[$];
    int   cyc = 0, ref_cyc = 0, hi_cnt = 0;
    bit   have_ref = 1'b0;
    bit   done = 1'b0;

    always #5 clk = ~clk;

    pwm_carrier_gen dut_i (
        .clk(clk), .rst_n(rst_n), .startup_done(startup_done),
        .strap_code(strap_code), .freq_sel(freq_sel), .sync_in(sync_in),
        .sync_out(sync_out), .sync_drive(sync_drive), .ramp_cnt(ramp_cnt),
        .period_start(period_start), .locked(locked), .is_slave(is_slave),
        .gain_idx(gain_idx), .cfg_err(cfg_err), .sync_lost(sync_lost)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Monitor: measure period length and sync-high cycles between strobes.
    always @(posedge clk) begin
        #2;
        cyc++;
        if (!rst_n) begin
            have_ref = 1'b0;
            hi_cnt   = 0;
        end else begin
            if (period_start) begin
                if (have_ref && q.size() > 0) begin
                    exp_t e;
                    e = q.pop_front();
                    chk(cyc - ref_cyc == e.ivl, e.tag, cyc - ref_cyc, e.ivl);
                    chk(hi_cnt == e.hi, "R6", hi_cnt, e.hi);
                end
                have_ref = 1'b1;
                ref_cyc  = cyc;
                hi_cnt   = 0;
            end
            if (sync_out) hi_cnt++;
        end
    end

    task automatic wait_strobe();
        do @(negedge clk); while (!period_start);
    endtask

    task automatic drain();
        while (q.size() > 0) @(negedge clk);
    endtask

    // Driver: change rate right after a strobe; old length, then new twice.
    task automatic run_code(input int old_div, input logic [2:0] code,
                            input int new_div, input string tag);
        wait_strobe();
        freq_sel = code;
        q.push_back('{old_div, old_div / 2, "R5"});
        q.push_back('{new_div, new_div / 2, tag});
        q.push_back('{new_div, new_div / 2, tag});
        drain();
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        startup_done = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic do_lock(input logic [2:0] s);
        strap_code = s;
        repeat (5) @(negedge clk);
        startup_done = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(ramp_cnt == 0 && !period_start && !locked, "R1", ramp_cnt, 0);
        chk(!sync_drive && !sync_out && !cfg_err && !sync_lost, "R1", sync_drive, 0);
        do_reset();
        chk(ramp_cnt == 0 && !period_start && !locked, "R1", locked, 0);

        // R9: idle before capture
        strap_code = 3'b010;
        repeat (20) @(negedge clk);
        chk(ramp_cnt == 0 && !period_start, "R9", ramp_cnt, 0);
        chk(!sync_drive, "R9", sync_drive, 0);

        // R2: master capture, gain 32 dB (index 2)
        do_lock(3'b010);
        chk(locked && !is_slave, "R2", is_slave, 0);
        chk(gain_idx == 2'd2, "R2", gain_idx, 2);
        strap_code = 3'b101;
        startup_done = 1'b0;
        repeat (10) @(negedge clk);
        startup_done = 1'b1;
        repeat (4) @(negedge clk);
        chk(!is_slave && gain_idx == 2'd2, "R2", gain_idx, 2);
        chk(sync_drive, "R6", sync_drive, 1);

        // R3/R5/R6: walk the rate table
        run_code(120, 3'b001, 96, "R3");
        run_code(96, 3'b010, 80, "R3");
        run_code(80, 3'b011, 48, "R3");
        run_code(48, 3'b100, 40, "R3");
        chk(!cfg_err, "R4", cfg_err, 0);

        // R4: reserved code falls back to 120 and sets a sticky flag
        run_code(40, 3'b110, 120, "R4");
        chk(cfg_err, "R4", cfg_err, 1);
        run_code(120, 3'b000, 120, "R4");
        chk(cfg_err, "R4", cfg_err, 1);

        // Slave: strap 111 -> slave, gain 36 dB; nominal 48 cycles
        freq_sel = 3'b011;
        do_reset();
        chk(!cfg_err, "R1", cfg_err, 0);
        do_lock(3'b111);
        chk(locked && is_slave && gain_idx == 2'd3, "R2", gain_idx, 3);
        chk(!sync_drive && !sync_out, "R7", sync_drive, 0);

        // R7: follow a 40-cycle sync clock
        repeat (2) begin
            sync_in = 1'b1; repeat (20) @(negedge clk);
            sync_in = 1'b0; repeat (20) @(negedge clk);
        end
        q.push_back('{40, 0, "R7"});
        q.push_back('{40, 0, "R7"});
        q.push_back('{40, 0, "R7"});
        repeat (4) begin
            sync_in = 1'b1; repeat (20) @(negedge clk);
            sync_in = 1'b0; repeat (20) @(negedge clk);
        end
        chk(q.size() == 0, "R7", q.size(), 0);
        q.delete();
        chk(!sync_lost, "R8", sync_lost, 0);

        // R7: exact restart cycle
        sync_in = 1'b1;
        repeat (2) @(posedge clk);
        #2;
        chk(ramp_cnt != 0 && !period_start, "R7", ramp_cnt, 1);
        @(posedge clk);
        #2;
        chk(ramp_cnt == 0 && period_start, "R7", ramp_cnt, 0);

        // R8: loss after 2 x 48 cycles without an edge
        repeat (90) @(posedge clk);
        #2;
        chk(!sync_lost, "R8", sync_lost, 0);
        repeat (10) @(posedge clk);
        #2;
        chk(sync_lost, "R8", sync_lost, 1);
        @(negedge clk);
        sync_in = 1'b0;
        repeat (3) @(negedge clk);
        sync_in = 1'b1;
        repeat (4) @(negedge clk);
        chk(!sync_lost, "R8", sync_lost, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule